// File: doc/BRIEF.md
# Trap and Interrupt Control Unit

This unit sits beside a processor pipeline. It decides, cycle by cycle, whether the instruction now at the head of the pipeline must be abandoned in favour of a trap handler. Two kinds of event can cause a trap. The first is a synchronous exception pulse raised by the pipeline: a load fault, a store fault, a divide by zero, an illegal opcode or an arithmetic overflow. The second is an enabled external interrupt request on one of eight levels. Both kinds of event follow the same path. The unit asserts the trap signal and redirects fetch to one fixed handler address. In the same cycle it captures the address of the current instruction, and it records in a cause register what happened.

Software inspects and adjusts the unit through a small indexed register port. Three registers are visible there. The status register holds a global interrupt enable, a saved copy of that enable, and a per-level mask. The cause register holds the pending request levels and a five-bit event code. The saved-PC register holds the address captured at the last trap. A return strobe from the handler restores the enable and redirects fetch to the saved address.

Control is a two-state machine. In `ST_USER`, normal code runs. The transition **TAKE** occurs on any trap and moves the machine to `ST_HANDLER`. In `ST_HANDLER`, the transition **NEST** occurs on a further exception or an enabled interrupt: the machine stays in `ST_HANDLER` and the trap is taken again. The transition **RETURN** occurs on a return strobe when no trap is raised in the same cycle, and moves the machine back to `ST_USER`. A return strobe seen in `ST_USER` has no effect.

Top module: `trap_ctrl`

## Requirements
- R1: After reset, all three registers (index 0 status, 1 cause, 2 saved PC) read zero, and index 3 reads zero. With no exception, trap_o, redirect_o and target_pc_o stay low.
- R2: While status bit 0 (global enable) is clear, no interrupt request causes a trap.
- R3: Request line k causes a trap only if status bit 8+k (its mask bit) is set and global enable is set.
- R4: Cause bit 8+k equals request line k as sampled at the previous clock edge. This holds whatever the mask and enable settings are.
- R5: Each trap writes cause bits 6:2 with the event code. The code is 0 for an interrupt. For the exception lines it is: exc_i[0] load fault 4, exc_i[1] store fault 5, exc_i[2] divide by zero 9, exc_i[3] illegal opcode 10, exc_i[4] overflow 12.
- R6: Any raised exception line causes a trap, whatever the enable and mask settings, and takes precedence over interrupts in the same cycle. When several exception lines are raised, the lowest code is recorded.
- R7: In a trap cycle, trap_o and redirect_o are high and target_pc_o is the handler address 32'h8000_0180. pc_i is saved into the saved-PC register.
- R8: A trap clears status bit 0 and copies its previous value into status bit 1.
- R9: In ST_HANDLER, a return strobe with no trap in the same cycle does three things. It raises redirect_o with target_pc_o equal to the saved PC. It copies status bit 1 into status bit 0. It returns the machine to ST_USER. In ST_USER, a return strobe has no effect on the outputs or on the registers.
- R10: A write to status updates bits 0, 1 and 15:8, and the other bits read zero. A write to the saved-PC register replaces it. Writes to the cause register and to index 3 are ignored.
- R11: A trap or return in the same cycle as a register write takes precedence: the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 8 | External interrupt request levels |
| exc_i | input | 5 | Synchronous exception pulses (see R5) |
| pc_i | input | 32 | Address of the current instruction |
| eret_i | input | 1 | Return-from-trap strobe |
| reg_addr_i | input | 2 | Register index for read and write |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| trap_o | output | 1 | Trap taken this cycle |
| redirect_o | output | 1 | Fetch redirect this cycle (trap or return) |
| target_pc_o | output | 32 | Redirect address; zero when no redirect |
| reg_rdata_o | output | 32 | Read data of the indexed register |

## Verification
Directed patterns drive interrupt requests that are masked, unmasked and enable-gated, so that a mask fault can be told apart from an enable fault. They also drive single and multiple exception lines, with and without competing interrupts, which separates the priority encoding from the interrupt path. Return strobes are issued in both machine states, and register writes coincide with traps, to show which side wins. A long pseudo-random stretch then mixes every input, and a behavioural model compares all outputs every cycle.

// File: rtl/trap_pkg.sv
package trap_pkg;
    typedef enum logic [0:0] {ST_USER, ST_HANDLER} mode_e;

    localparam int NUM_EXC = 5;
    localparam int CODE_W  = 5;

    localparam logic [CODE_W-1:0] CODE_INT     = 5'd0;
    localparam logic [CODE_W-1:0] CODE_LOAD    = 5'd4;
    localparam logic [CODE_W-1:0] CODE_STORE   = 5'd5;
    localparam logic [CODE_W-1:0] CODE_DIV0    = 5'd9;
    localparam logic [CODE_W-1:0] CODE_ILLEGAL = 5'd10;
    localparam logic [CODE_W-1:0] CODE_OVF     = 5'd12;

    localparam logic [1:0] IDX_STATUS = 2'd0;
    localparam logic [1:0] IDX_CAUSE  = 2'd1;
    localparam logic [1:0] IDX_EPC    = 2'd2;

    // exception line index to code; line order equals code order
    function automatic logic [CODE_W-1:0] line_code(input int idx);
        case (idx)
            0:       line_code = CODE_LOAD;
            1:       line_code = CODE_STORE;
            2:       line_code = CODE_DIV0;
            3:       line_code = CODE_ILLEGAL;
            default: line_code = CODE_OVF;
        endcase
    endfunction
endpackage

// File: rtl/trap_prio.sv
module trap_prio
    import trap_pkg::*;
#(
    parameter int N = NUM_EXC
) (
    input  logic [N-1:0]      req,
    output logic              any,
    output logic [CODE_W-1:0] code
);
    logic [N-1:0]      win;
    logic [CODE_W-1:0] code_part [N];

    for (genvar i = 0; i < N; i++) begin : g_line
        if (i == 0) begin : g_first
            assign win[i] = req[i];
        end else begin : g_rest
            assign win[i] = req[i] & ~(|req[i-1:0]);
        end
        assign code_part[i] = win[i] ? line_code(i) : '0;
    end

    always_comb begin
        code = '0;
        for (int i = 0; i < N; i++) begin
            code = code | code_part[i];
        end
    end

    assign any = |req;
endmodule

// File: rtl/trap_csr.sv
module trap_csr
    import trap_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int NUM_IRQ  = 8,
    parameter int MASK_LSB = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_IRQ-1:0]  irq,
    input  logic                take,
    input  logic [CODE_W-1:0]   take_code,
    input  logic [XLEN-1:0]     pc,
    input  logic                restore,
    input  logic [1:0]          addr,
    input  logic                we,
    input  logic [XLEN-1:0]     wdata,
    output logic                ie,
    output logic                pie,
    output logic [NUM_IRQ-1:0]  mask,
    output logic [NUM_IRQ-1:0]  pend,
    output logic [CODE_W-1:0]   code,
    output logic [XLEN-1:0]     epc,
    output logic [XLEN-1:0]     rdata
);
    logic wd_unused;
    assign wd_unused = ^wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie   <= 1'b0;
            pie  <= 1'b0;
            mask <= '0;
            pend <= '0;
            code <= '0;
            epc  <= '0;
        end else begin
            pend <= irq;
            if (take) begin
                ie   <= 1'b0;
                pie  <= ie;
                code <= take_code;
                epc  <= pc;
            end else if (restore) begin
                ie <= pie;
            end else if (we) begin
                if (addr == IDX_STATUS) begin
                    ie   <= wdata[0];
                    pie  <= wdata[1];
                    mask <= wdata[MASK_LSB +: NUM_IRQ];
                end else if (addr == IDX_EPC) begin
                    epc <= wdata;
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            IDX_STATUS: begin
                rdata[0]                   = ie;
                rdata[1]                   = pie;
                rdata[MASK_LSB +: NUM_IRQ] = mask;
            end
            IDX_CAUSE: begin
                rdata[MASK_LSB +: NUM_IRQ] = pend;
                rdata[2 +: CODE_W]         = code;
            end
            IDX_EPC: rdata = epc;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
    import trap_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              NUM_IRQ  = 8,
    parameter logic [XLEN-1:0] VECTOR   = 32'h8000_0180
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_IRQ-1:0]  irq_i,
    input  logic [NUM_EXC-1:0]  exc_i,
    input  logic [XLEN-1:0]     pc_i,
    input  logic                eret_i,
    input  logic [1:0]          reg_addr_i,
    input  logic                reg_we_i,
    input  logic [XLEN-1:0]     reg_wdata_i,
    output logic                trap_o,
    output logic                redirect_o,
    output logic [XLEN-1:0]     target_pc_o,
    output logic [XLEN-1:0]     reg_rdata_o
);
    localparam int MASK_LSB = 8;

    mode_e             state_q, state_d;
    logic              in_handler;
    logic              exc_any, irq_hit, take, restore;
    logic [CODE_W-1:0] exc_code, take_code;
    logic              st_ie, st_pie;
    logic [NUM_IRQ-1:0] st_mask, cs_pend;
    logic [CODE_W-1:0] cs_code;
    logic [XLEN-1:0]   epc_q;

    trap_prio #(.N(NUM_EXC)) u_prio (
        .req  (exc_i),
        .any  (exc_any),
        .code (exc_code)
    );

    assign irq_hit    = st_ie & (|(irq_i & st_mask));
    assign take       = exc_any | irq_hit;
    assign take_code  = exc_any ? exc_code : CODE_INT;
    assign in_handler = (state_q == ST_HANDLER);
    assign restore    = in_handler & eret_i & ~take;

    trap_csr #(.XLEN(XLEN), .NUM_IRQ(NUM_IRQ), .MASK_LSB(MASK_LSB)) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq       (irq_i),
        .take      (take),
        .take_code (take_code),
        .pc        (pc_i),
        .restore   (restore),
        .addr      (reg_addr_i),
        .we        (reg_we_i),
        .wdata     (reg_wdata_i),
        .ie        (st_ie),
        .pie       (st_pie),
        .mask      (st_mask),
        .pend      (cs_pend),
        .code      (cs_code),
        .epc       (epc_q),
        .rdata     (reg_rdata_o)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_USER;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d     = state_q;
        trap_o      = 1'b0;
        redirect_o  = 1'b0;
        target_pc_o = '0;
        unique case (state_q)
            ST_USER: begin
                if (take) begin            // TAKE
                    state_d     = ST_HANDLER;
                    trap_o      = 1'b1;
                    redirect_o  = 1'b1;
                    target_pc_o = VECTOR;
                end
            end
            ST_HANDLER: begin
                if (take) begin            // NEST
                    trap_o      = 1'b1;
                    redirect_o  = 1'b1;
                    target_pc_o = VECTOR;
                end else if (restore) begin // RETURN
                    state_d     = ST_USER;
                    redirect_o  = 1'b1;
                    target_pc_o = epc_q;
                end
            end
        endcase
    end
endmodule

// File: rtl/trap_ctrl_chk.sv
module trap_ctrl_chk
    import trap_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int NUM_IRQ = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               trap,
    input logic [NUM_IRQ-1:0] irq,
    input logic [NUM_EXC-1:0] exc,
    input logic [XLEN-1:0]    pc,
    input logic               eret,
    input logic               ie,
    input logic               pie,
    input logic [NUM_IRQ-1:0] mask,
    input logic [NUM_IRQ-1:0] pend,
    input logic [CODE_W-1:0]  code,
    input logic [XLEN-1:0]    epc,
    input logic               in_handler
);
    a_r2_disabled_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie && exc == '0) |-> !trap);

    a_r3_masked_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (exc == '0 && (irq & mask) == '0) |-> !trap);

    a_r4_pending_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> pend == $past(irq));

    a_r5_irq_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (trap && exc == '0) |=> code == CODE_INT);

    a_r6_exc_traps: assert property (@(posedge clk) disable iff (!rst_n)
        (exc != '0) |-> trap);

    a_r7_pc_saved: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> epc == $past(pc));

    a_r8_enable_stacked: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> (!ie && pie == $past(ie) && in_handler));

    a_r9_return_restores: assert property (@(posedge clk) disable iff (!rst_n)
        (eret && in_handler && !trap) |=> (ie == $past(pie) && !in_handler));
endmodule

bind trap_ctrl trap_ctrl_chk #(.XLEN(XLEN), .NUM_IRQ(NUM_IRQ)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trap       (trap_o),
    .irq        (irq_i),
    .exc        (exc_i),
    .pc         (pc_i),
    .eret       (eret_i),
    .ie         (st_ie),
    .pie        (st_pie),
    .mask       (st_mask),
    .pend       (cs_pend),
    .code       (cs_code),
    .epc        (epc_q),
    .in_handler (in_handler)
);

// File: tb/trap_ctrl_tb.sv
`timescale 1ns/1ps
module trap_ctrl_tb;
    localparam logic [31:0] VEC = 32'h8000_0180;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  irq_i = '0;
    logic [4:0]  exc_i = '0;
    logic [31:0] pc_i = '0;
    logic        eret_i = 1'b0;
    logic [1:0]  reg_addr_i = '0;
    logic        reg_we_i = 1'b0;
    logic [31:0] reg_wdata_i = '0;
    logic        trap_o, redirect_o;
    logic [31:0] target_pc_o, reg_rdata_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    bit          m_ie, m_pie, m_hand;
    logic [7:0]  m_mask, m_pend;
    logic [4:0]  m_code;
    logic [31:0] m_epc;

    always #2.5 clk = ~clk;

    trap_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .exc_i(exc_i), .pc_i(pc_i),
        .eret_i(eret_i), .reg_addr_i(reg_addr_i), .reg_we_i(reg_we_i),
        .reg_wdata_i(reg_wdata_i), .trap_o(trap_o), .redirect_o(redirect_o),
        .target_pc_o(target_pc_o), .reg_rdata_o(reg_rdata_o)
    );

    function automatic logic [31:0] model_read(input logic [1:0] a);
        logic [31:0] r = 0;
        if (a == 0) begin r[0] = m_ie; r[1] = m_pie; r[15:8] = m_mask; end
        else if (a == 1) begin r[15:8] = m_pend; r[6:2] = m_code; end
        else if (a == 2) r = m_epc;
        return r;
    endfunction

    function automatic logic [4:0] model_exc_code(input logic [4:0] e);
        int table_codes[5] = '{4, 5, 9, 10, 12};
        for (int i = 0; i < 5; i++) if (e[i]) return 5'(table_codes[i]);
        return 5'd0;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag, input logic [7:0] irq, input logic [4:0] exc,
                        input logic [31:0] pc, input logic eret, input logic [1:0] addr,
                        input logic we, input logic [31:0] wd);
        bit take, rest;
        logic [31:0] tgt;
        irq_i = irq; exc_i = exc; pc_i = pc; eret_i = eret;
        reg_addr_i = addr; reg_we_i = we; reg_wdata_i = wd;
        #1;
        take = (exc != 0) || (m_ie && ((irq & m_mask) != 0));
        rest = m_hand && eret && !take;
        tgt  = take ? VEC : (rest ? m_epc : 32'h0);
        check(tag, "trap_o", {31'b0, trap_o}, {31'b0, take});
        check(tag, "redirect_o", {31'b0, redirect_o}, {31'b0, take | rest});
        check(tag, "target_pc_o", target_pc_o, tgt);
        check(tag, "reg_rdata_o", reg_rdata_o, model_read(addr));
        @(posedge clk);
        if (take) begin
            m_pie = m_ie; m_ie = 0; m_code = exc != 0 ? model_exc_code(exc) : 5'd0;
            m_epc = pc; m_hand = 1;
        end else if (rest) begin
            m_ie = m_pie; m_hand = 0;
        end else if (we) begin
            if (addr == 0) begin m_ie = wd[0]; m_pie = wd[1]; m_mask = wd[15:8]; end
            else if (addr == 2) m_epc = wd;
        end
        m_pend = irq;
        @(negedge clk);
    endtask

    task automatic rd(input string tag, input logic [1:0] a);
        step(tag, 8'h0, 5'h0, 32'h0, 1'b0, a, 1'b0, 32'h0);
    endtask

    initial begin
        #(5 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        m_ie = 0; m_pie = 0; m_hand = 0; m_mask = 0; m_pend = 0; m_code = 0; m_epc = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 4; a++) rd("R1", 2'(a));
        // R10 register writes
        step("R10", 0, 0, 0, 0, 2'd0, 1, 32'hFFFF_FF03);
        rd("R10", 2'd0);
        step("R10", 0, 0, 0, 0, 2'd1, 1, 32'hFFFF_FFFF);
        rd("R10", 2'd1);
        step("R10", 0, 0, 0, 0, 2'd2, 1, 32'h0000_1234);
        rd("R10", 2'd2);
        step("R10", 0, 0, 0, 0, 2'd3, 1, 32'hDEAD_BEEF);
        rd("R10", 2'd3);
        // R2 enable clear, mask all set
        step("R2", 0, 0, 0, 0, 2'd0, 1, 32'h0000_FF00);
        step("R2", 8'h01, 0, 32'h100, 0, 2'd1, 0, 0);
        step("R4", 8'h81, 0, 32'h104, 0, 2'd1, 0, 0);
        rd("R4", 2'd1);
        // R3 only level 7 (status bit 15) unmasked
        step("R3", 0, 0, 0, 0, 2'd0, 1, 32'h0000_8001);
        step("R3", 8'h7F, 0, 32'h200, 0, 2'd1, 0, 0);
        step("R3", 8'h80, 0, 32'h204, 0, 2'd0, 0, 0);
        step("R5", 8'h80, 0, 32'h208, 0, 2'd1, 0, 0);
        rd("R7", 2'd2);
        rd("R8", 2'd0);
        // R9 return in handler, then in user
        step("R9", 0, 0, 32'h300, 1, 2'd0, 0, 0);
        rd("R9", 2'd0);
        step("R9", 0, 0, 32'h304, 1, 2'd0, 0, 0);
        rd("R9", 2'd0);
        // R6 exceptions, single and combined
        for (int i = 0; i < 5; i++) begin
            step("R6", 0, 5'(1 << i), 32'h400 + 32'(i), 0, 2'd1, 0, 0);
            step("R5", 0, 0, 0, 1, 2'd1, 0, 0);
        end
        step("R6", 8'hFF, 5'b11010, 32'h500, 0, 2'd1, 0, 0);
        step("R6", 8'hFF, 5'b10100, 32'h504, 0, 2'd1, 0, 0);
        rd("R6", 2'd1);
        // R11 write vs trap, write vs return
        step("R11", 0, 5'b00001, 32'h600, 0, 2'd0, 1, 32'h0000_0003);
        rd("R11", 2'd0);
        step("R11", 0, 0, 0, 1, 2'd2, 1, 32'h0000_7777);
        rd("R11", 2'd2);
        // nested exception in handler
        step("R8", 0, 5'b01000, 32'h700, 0, 2'd0, 0, 0);
        step("R8", 0, 5'b00010, 32'h704, 0, 2'd0, 0, 0);
        rd("R8", 2'd0);
        // mixed pseudo-random traffic
        for (int n = 0; n < 600; n++) begin
            logic [4:0] e;
            e = ($urandom % 5 == 0) ? 5'($urandom) : 5'd0;
            step("R6", 8'($urandom), e, $urandom, ($urandom % 3 == 0),
                 2'($urandom), ($urandom % 4 == 0), $urandom);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule